// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial input into parallel characters. A start bit is qualified, data bits arrive least significant first, an optional parity bit follows, and then one or two stop bits. Each character goes into a receive buffer that the host reads over a byte-wide port.

A status byte sits beside the buffer. It holds three error flags: overrun, parity mismatch and missing stop bit. Timing comes from an external sample tick that runs at sixteen times the bit rate. The block has no baud-rate generator.

The host picks one of the two registers with a select input. A read strobe with the buffer selected marks the character as consumed. A read strobe with the status byte selected has no effect.

Top module: `serial_rx_stat`

## Requirements
- R1: After reset, the status byte reads 0x00 and the data buffer reads 0x00. Status bits 7 to 3 always read 0.
- R2: The status byte layout is bit 0 = overrun, bit 1 = parity error, bit 2 = framing error. It is shown on `rd_data_o` when `rd_sel_i`=1. A strobe on the status byte changes no flag and no buffer content.
- R3: Each bit lasts 16 ticks of `smp_tick_i`. Each bit is sampled once, near its middle. The 8 data bits are received least significant bit first.
- R4: After a falling edge, the line is checked again 8 ticks later. If it is high by then, the event is dropped and no character is produced.
- R5: With `par_en_i`=1, the parity error flag is set when the received parity bit differs from the XOR of the data bits, inverted when `par_odd_i`=1. With `par_en_i`=0, the flag reads 0.
- R6: The framing error flag is set when the first stop bit is sampled low.
- R7: With `two_stop_i`=1, the second stop bit is skipped without being checked. A low second stop bit raises no flag and starts no new character.
- R8: If a character completes while the buffer still holds an unread character, the overrun flag is set. The buffer keeps the older character and the new one is lost.
- R9: Overrun is raised again by every character that completes while the buffer is unread. A buffer read (`rd_en_i`=1, `rd_sel_i`=0) clears the overrun flag and frees the buffer.
- R10: The parity and framing flags change only when a character completes. Both are then replaced by that character's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| smp_tick_i | input | 1 | Sample tick, one-cycle pulse at 16x the bit rate |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | Two stop bits per character |
| rd_sel_i | input | 1 | 0 = data buffer, 1 = status byte |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Selected register contents |

## Verification
On every cycle, the assertions check the following:
- The status byte padding reads zero.
- A completion pulse lasts one cycle.
- Overrun rises only while the buffer is full, and an overrun leaves the buffer unchanged.
- A buffer read clears overrun and frees the buffer.
- The parity and framing flags stay put between completions.

Some behaviour only the bench scenarios can show:
- Bit order on the line.
- Rejection of a start glitch.
- The two parity senses.
- That a low second stop bit is ignored.
- That overrun recurs over several characters until the buffer is read.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RXS_IDLE  = 3'd0,
    RXS_START = 3'd1,
    RXS_DATA  = 3'd2,
    RXS_PAR   = 3'd3,
    RXS_STOP  = 3'd4,
    RXS_STOP2 = 3'd5
  } rx_state_e;

  typedef struct packed {
    logic fe;
    logic pe;
    logic ovr;
  } rx_flags_t;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          two_stop_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] TOPB = BW'(DW - 1);

  rx_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic pbit_q, pbit_d;
  logic done_q, done_d;
  logic perr_q, perr_d;
  logic ferr_q, ferr_d;
  logic at_mid, at_last;

  assign at_mid  = tick_i && (cnt_q == MID);
  assign at_last = tick_i && (cnt_q == LAST);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    pbit_d = pbit_q;
    done_d = 1'b0;
    perr_d = perr_q;
    ferr_d = ferr_q;
    if (tick_i && !at_last) cnt_d = cnt_q + 1'b1;
    case (st_q)
      RXS_IDLE: begin
        cnt_d = '0;
        if (tick_i && !rx_i) st_d = RXS_START;
      end
      RXS_START: begin
        if (at_mid) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = rx_i ? RXS_IDLE : RXS_DATA;
        end
      end
      RXS_DATA: begin
        if (at_last) begin
          cnt_d = '0;
          sh_d  = {rx_i, sh_q[DW-1:1]};
          bit_d = bit_q + 1'b1;
          if (bit_q == TOPB) st_d = par_en_i ? RXS_PAR : RXS_STOP;
        end
      end
      RXS_PAR: begin
        if (at_last) begin
          cnt_d  = '0;
          pbit_d = rx_i;
          st_d   = RXS_STOP;
        end
      end
      RXS_STOP: begin
        if (at_last) begin
          cnt_d  = '0;
          done_d = 1'b1;
          ferr_d = !rx_i;
          perr_d = par_en_i && (pbit_q != ((^sh_q) ^ par_odd_i));
          st_d   = two_stop_i ? RXS_STOP2 : RXS_IDLE;
        end
      end
      RXS_STOP2: begin
        if (at_last) begin
          cnt_d = '0;
          st_d  = RXS_IDLE;
        end
      end
      default: st_d = RXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RXS_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      pbit_q <= pbit_d;
      done_q <= done_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
endmodule

// File: rtl/serial_rx_buf.sv
module serial_rx_buf
  import serial_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  input  logic          consume_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output rx_flags_t     flags_o
);
  logic [DW-1:0] dat_q, dat_d;
  logic full_q, full_d;
  rx_flags_t fl_q, fl_d;
  logic still_full;

  always_comb begin
    dat_d      = dat_q;
    fl_d       = fl_q;
    still_full = full_q && !consume_i;
    full_d     = still_full;
    if (consume_i) fl_d.ovr = 1'b0;
    if (done_i) begin
      fl_d.pe = perr_i;
      fl_d.fe = ferr_i;
      if (still_full) begin
        fl_d.ovr = 1'b1;
      end else begin
        dat_d    = data_i;
        full_d   = 1'b1;
        fl_d.ovr = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      full_q <= 1'b0;
      fl_q   <= '0;
    end else begin
      dat_q  <= dat_d;
      full_q <= full_d;
      fl_q   <= fl_d;
    end
  end

  assign data_o  = dat_q;
  assign full_o  = full_q;
  assign flags_o = fl_q;
endmodule

// File: rtl/serial_rx_stat.sv
module serial_rx_stat
  import serial_rx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          smp_tick_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          two_stop_i,
  input  logic          rd_sel_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int PAD = DW - 3;

  logic          rx_s;
  logic          frm_done;
  logic [DW-1:0] frm_data;
  logic          frm_perr;
  logic          frm_ferr;
  logic [DW-1:0] buf_data;
  logic          buf_full;
  logic          buf_take;
  rx_flags_t     flags;
  logic          ovr_flag, pe_flag, fe_flag;

  serial_rx_sync #(.STAGES(SYNC)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  serial_rx_frame #(.DW(DW), .OVS(OVS)) frame_i (
    .clk(clk), .rst_n(rst_n), .tick_i(smp_tick_i), .rx_i(rx_s),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .two_stop_i(two_stop_i),
    .done_o(frm_done), .data_o(frm_data), .perr_o(frm_perr), .ferr_o(frm_ferr)
  );

  assign buf_take = rd_en_i && !rd_sel_i;

  serial_rx_buf #(.DW(DW)) buf_i (
    .clk(clk), .rst_n(rst_n), .done_i(frm_done), .data_i(frm_data),
    .perr_i(frm_perr), .ferr_i(frm_ferr), .consume_i(buf_take),
    .data_o(buf_data), .full_o(buf_full), .flags_o(flags)
  );

  assign ovr_flag = flags.ovr;
  assign pe_flag  = flags.pe;
  assign fe_flag  = flags.fe;

  always_comb begin
    if (rd_sel_i) rd_data_o = {{PAD{1'b0}}, fe_flag, pe_flag, ovr_flag};
    else          rd_data_o = buf_data;
  end
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_sel,
  input logic [DW-1:0] rd_data,
  input logic          done,
  input logic          full,
  input logic          ovr,
  input logic          pe,
  input logic          fe,
  input logic [DW-1:0] dbuf
);
  a_r1_status_pad: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> (rd_data[DW-1:3] == '0));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full && !(rd_en && !rd_sel)) |=> (ovr && $stable(dbuf)));

  a_r8_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(full));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !done) |=> (!ovr && !full));

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable({pe, fe}));
endmodule

bind serial_rx_stat serial_rx_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en_i), .rd_sel(rd_sel_i),
  .rd_data(rd_data_o), .done(frm_done), .full(buf_full), .ovr(ovr_flag),
  .pe(pe_flag), .fe(fe_flag), .dbuf(buf_data)
);

// File: tb/serial_rx_stat_tb_top.sv
module serial_rx_stat_tb_top;
  localparam int TDIV = 4;
  localparam int BT   = 16 * TDIV;

  typedef struct {
    logic [7:0] st;
    logic [7:0] dat;
    bit         take;
    logic [7:0] st_after;
    string      req;
  } exp_t;

  logic clk, rst_n, rx, tick, par_en, par_odd, two_stop, rd_sel, rd_en;
  logic [7:0] rd_data;
  int checks, errors, tcnt;
  exp_t sb[$];

  serial_rx_stat dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .smp_tick_i(tick),
    .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .rd_sel_i(rd_sel), .rd_en_i(rd_en), .rd_data_o(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tcnt <= 0;
      tick <= 1'b0;
    end else begin
      tcnt <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
      tick <= (tcnt == TDIV-1);
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hold_bits(input int n);
    repeat (n * BT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit pen, input bit podd,
                      input bit pflip, input bit stop1, input bit ts, input bit stop2);
    @(negedge clk);
    par_en = pen; par_odd = podd; two_stop = ts;
    rx = 1'b0; hold_bits(1);
    for (int i = 0; i < 8; i++) begin
      rx = d[i]; hold_bits(1);
    end
    if (pen) begin
      rx = (^d) ^ podd ^ pflip; hold_bits(1);
    end
    rx = stop1; hold_bits(1);
    if (ts) begin
      rx = stop2; hold_bits(1);
    end
    rx = 1'b1; hold_bits(2);
  endtask

  task automatic push(input logic [7:0] st, input logic [7:0] dat, input bit take,
                      input logic [7:0] st_after, input string req);
    exp_t e;
    e.st = st; e.dat = dat; e.take = take; e.st_after = st_after; e.req = req;
    sb.push_back(e);
  endtask

  task automatic monitor();
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      @(negedge clk); rd_sel = 1'b1; rd_en = 1'b1;
      #1 check(rd_data, e.st, {e.req, " status"});
      @(negedge clk); rd_sel = 1'b0; rd_en = e.take;
      #1 check(rd_data, e.dat, {e.req, " data"});
      @(negedge clk); rd_en = 1'b0; rd_sel = 1'b1;
      #1 check(rd_data, e.st_after, {e.req, " status after read"});
    end
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; rx = 1'b1; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    rd_sel = 1'b1; rd_en = 1'b0;
    repeat (5) @(negedge clk);
    #1 check(rd_data, 8'h00, "R1 reset status");
    rd_sel = 1'b0;
    #1 check(rd_data, 8'h00, "R1 reset data");
    rd_sel = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(8'hA5, 0, 0, 0, 1, 0, 1); push(8'h00, 8'hA5, 1, 8'h00, "R3 lsb first"); monitor();
    send(8'h3C, 1, 0, 0, 1, 0, 1); push(8'h00, 8'h3C, 1, 8'h00, "R5 even ok"); monitor();
    send(8'h3C, 1, 0, 1, 1, 0, 1); push(8'h02, 8'h3C, 1, 8'h02, "R5 even bad"); monitor();
    send(8'h3C, 0, 0, 0, 1, 0, 1); push(8'h00, 8'h3C, 1, 8'h00, "R10 pe replaced"); monitor();
    send(8'h96, 1, 1, 0, 1, 0, 1); push(8'h00, 8'h96, 1, 8'h00, "R5 odd ok"); monitor();
    send(8'h96, 1, 1, 1, 1, 0, 1); push(8'h02, 8'h96, 1, 8'h02, "R5 odd bad"); monitor();
    send(8'h0F, 0, 0, 0, 0, 0, 1); push(8'h04, 8'h0F, 1, 8'h04, "R6 framing"); monitor();
    send(8'hC3, 0, 0, 0, 1, 1, 0); push(8'h00, 8'hC3, 1, 8'h00, "R7 second stop ignored"); monitor();

    @(negedge clk); rx = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rx = 1'b1; hold_bits(12);
    push(8'h00, 8'hC3, 0, 8'h00, "R4 glitch no frame"); monitor();
    send(8'h5A, 0, 0, 0, 1, 0, 1); push(8'h00, 8'h5A, 1, 8'h00, "R4 next frame clean"); monitor();

    send(8'h11, 0, 0, 0, 1, 0, 1); push(8'h00, 8'h11, 0, 8'h00, "R2 status strobe no effect"); monitor();
    send(8'h22, 0, 0, 0, 1, 0, 1); push(8'h01, 8'h11, 0, 8'h01, "R8 overrun keeps old"); monitor();
    send(8'h33, 0, 0, 0, 1, 0, 1); push(8'h01, 8'h11, 1, 8'h00, "R9 recur then read clears"); monitor();
    send(8'h44, 0, 0, 0, 1, 0, 1); push(8'h00, 8'h44, 1, 8'h00, "R9 buffer freed"); monitor();
    send(8'h77, 1, 0, 1, 0, 0, 1); push(8'h06, 8'h77, 1, 8'h06, "R10 pe fe together"); monitor();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule